// File: doc/BRIEF.md
# Valley-Edge Period and Phase-Lag Capture

This block timestamps the valley instants of an interleaved boundary-mode boost stage. Each channel delivers a digital zero-current-detect level whose falling edge marks the valley. Channel 0 is the master. The block measures the master switching period as the clock count between two consecutive master falling edges, and it refreshes that value on every switching cycle. For every other channel it measures the lag, which is the clock count from a master falling edge to that channel's next falling edge. A slower control loop reads the held period and lag values whenever it runs. Update strobes show when a value is new.

Each raw input passes through a two-flop synchroniser and then a falling-edge detector. Because every channel has the same synchroniser delay, the measured lag equals the spacing of the raw edges. The counters stop at their all-ones value and do not wrap. If the master stays silent for longer than a parameterised timeout, the period is marked stale and the last value is held.

The master tracker has three states: `M_WAIT`, `M_MEASURE` and `M_STALE`.
- `M_WAIT` moves to `M_MEASURE` on the first master edge while enabled.
- `M_MEASURE` moves back to `M_MEASURE` on each edge, capturing the period.
- `M_MEASURE` moves to `M_STALE` when the timeout expires.
- `M_STALE` moves to `M_MEASURE` on an edge, without capturing.
- Any state moves to `M_WAIT` when the master enable is low.

Each slave tracker has three states: `S_IDLE`, `S_ARMED` and `S_TIMING`.
- `S_IDLE` moves to `S_ARMED` when the channel is enabled.
- `S_ARMED` moves to `S_TIMING` on a master edge.
- `S_TIMING` moves to `S_ARMED` on a slave edge, or restarts `S_TIMING` on a master edge. When both edges arrive together, the slave edge is evaluated first and timing then restarts.
- Any state moves to `S_IDLE` when the channel enable is low.

Top module: `zcd_capture`

## Requirements
- R1: Each high-to-low transition of a ZCD input, held low for at least two clocks, is taken as exactly one event. Rising transitions produce no event.
- R2: For two master events N clocks apart, with N no larger than TIMEOUT, `period_o` becomes N (saturated at 2^CNT_W-1). `period_upd_o` pulses for one clock when the new value appears.
- R3: After reset, all outputs are 0. The first master event after reset, after enable or after a stale period produces no capture. `period_valid_o` goes to 1 with the first capture and stays there until the master enable drops.
- R4: If more than TIMEOUT clocks pass with no master event, `period_stale_o` goes to 1 and `period_o` is held. The next master event clears the stale flag without a capture. An interval of exactly TIMEOUT clocks is still captured.
- R5: `period_o` and each lag output change only in the clock where their update strobe is high.
- R6: A slave event M clocks after the latest master event makes that slave's lag slice M. The slice for slave k is `lag_o[k*CNT_W-1 -: CNT_W]`, and `lag_upd_o[k-1]` pulses for one clock.
- R7: A lag is accepted only if `period_valid_o` is 1 and 0 < lag < current period. Otherwise `lag_err_o[k-1]` pulses for one clock and the slice keeps its old value. A lag equal to the period is rejected.
- R8: A slave event with no master event since that slave's last capture is ignored. A second master event before the slave event restarts the lag count.
- R9: While a channel's enable is low, its events are ignored and its outputs do not update. When the master is disabled, `period_valid_o` is cleared.
- R10: The period and lag counters saturate at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zcd_i | input | NCH | Raw asynchronous ZCD levels; bit 0 is the master |
| chan_en_i | input | NCH | Per-channel enable; bit 0 is the master |
| period_o | output | CNT_W | Held master period in clocks |
| period_valid_o | output | 1 | At least one period captured since enable |
| period_upd_o | output | 1 | One-clock pulse when period_o is refreshed |
| period_stale_o | output | 1 | Master timeout expired; period held |
| lag_o | output | (NCH-1)*CNT_W | Held lag per slave; slave k uses slice k-1 |
| lag_upd_o | output | NCH-1 | One-clock pulse per slave when its lag is refreshed |
| lag_err_o | output | NCH-1 | One-clock pulse per slave when a lag is rejected |

## Verification
The hardest case to reach is a slave edge that lands in the same clock as a master edge while that slave is still timing. In that clock the out-of-range lag must be rejected and a fresh count must start from the same edge. The stimulus drives both raw inputs low on the same clock. It does this only after letting the slave miss a whole period, so the rejected lag equals the held period exactly. The saturation and timeout edges are reached by building the bench with an 8-bit counter and a 600-clock timeout. That makes a 300-clock interval saturate, lets an interval of exactly 600 clocks still capture, and lets a 700-clock gap go stale.

// File: rtl/zcap_pkg.sv
package zcap_pkg;

    // Master period tracker states
    typedef enum logic [1:0] {
        M_WAIT    = 2'd0,
        M_MEASURE = 2'd1,
        M_STALE   = 2'd2
    } mst_state_e;

    // Slave lag tracker states
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ARMED  = 2'd1,
        S_TIMING = 2'd2
    } slv_state_e;

    localparam int unsigned ZCAP_SYNC_STAGES = 2;

endpackage

// File: rtl/zcap_edge.sv
module zcap_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic fall_o
);
    // Synchroniser stages plus one history stage; idle level is high.
    logic [SYNC_STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '1;
        end else begin
            shift_q <= {shift_q[SYNC_STAGES-1:0], raw_i};
        end
    end

    assign fall_o = shift_q[SYNC_STAGES] & ~shift_q[SYNC_STAGES-1];

    // A falling edge lasts one clock only.
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/zcap_master.sv
module zcap_master
    import zcap_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned TIMEOUT = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             edge_i,
    output logic [CNT_W-1:0] period_o,
    output logic             valid_o,
    output logic             upd_o,
    output logic             stale_o
);
    localparam int unsigned     TO_W    = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [TO_W-1:0]  TO_LAST = TO_W'(TIMEOUT - 1);

    mst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [TO_W-1:0]  tcnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    assign hit     = en_i & edge_i;
    assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_WAIT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_WAIT: begin
                if (hit) state_d = M_MEASURE;
            end
            M_MEASURE: begin
                if (!en_i)                 state_d = M_WAIT;
                else if (edge_i)           state_d = M_MEASURE;
                else if (tcnt_q == TO_LAST) state_d = M_STALE;
            end
            M_STALE: begin
                if (!en_i)       state_d = M_WAIT;
                else if (edge_i) state_d = M_MEASURE;
            end
            default: state_d = M_WAIT;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tcnt_q   <= '0;
            period_o <= '0;
            valid_o  <= 1'b0;
            upd_o    <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (!en_i) valid_o <= 1'b0;
            unique case (state_q)
                M_MEASURE: begin
                    if (hit) begin
                        period_o <= cnt_inc;
                        valid_o  <= 1'b1;
                        upd_o    <= 1'b1;
                        cnt_q    <= '0;
                        tcnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_inc;
                        if (tcnt_q != TO_LAST) tcnt_q <= tcnt_q + TO_W'(1);
                    end
                end
                M_WAIT, M_STALE: begin
                    if (hit) begin
                        cnt_q  <= '0;
                        tcnt_q <= '0;
                    end
                end
                default: begin
                    cnt_q  <= '0;
                    tcnt_q <= '0;
                end
            endcase
        end
    end

    assign stale_o = (state_q == M_STALE);

    assert_upd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> valid_o);

    assert_period_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (period_o != '0));

    assert_stale_no_upd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stale_o |-> !upd_o);

    assert_period_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(period_o));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0));

endmodule

// File: rtl/zcap_slave.sv
module zcap_slave
    import zcap_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             m_edge_i,
    input  logic             s_edge_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             period_valid_i,
    output logic [CNT_W-1:0] lag_o,
    output logic             upd_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    slv_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lag_now;
    logic             in_range;

    assign lag_now  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
    assign in_range = period_valid_i && (lag_now != '0) && (lag_now < period_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (en_i) state_d = S_ARMED;
            end
            S_ARMED: begin
                if (!en_i)         state_d = S_IDLE;
                else if (m_edge_i) state_d = S_TIMING;
            end
            S_TIMING: begin
                if (!en_i)         state_d = S_IDLE;
                else if (m_edge_i) state_d = S_TIMING;
                else if (s_edge_i) state_d = S_ARMED;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lag_o <= '0;
            upd_o <= 1'b0;
            err_o <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            err_o <= 1'b0;
            if (en_i && state_q == S_TIMING && s_edge_i) begin
                if (in_range) begin
                    lag_o <= lag_now;
                    upd_o <= 1'b1;
                end else begin
                    err_o <= 1'b1;
                end
            end
            if (en_i && m_edge_i)         cnt_q <= '0;
            else if (state_q == S_TIMING) cnt_q <= lag_now;
        end
    end

    assert_lag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (lag_o != '0 && lag_o < $past(period_i)));

    assert_upd_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_o && err_o));

    assert_lag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(lag_o));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!upd_o && !err_o));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0));

endmodule

// File: rtl/zcd_capture.sv
module zcd_capture
    import zcap_pkg::*;
#(
    parameter int unsigned NCH     = 3,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned TIMEOUT = 50000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             zcd_i,
    input  logic [NCH-1:0]             chan_en_i,
    output logic [CNT_W-1:0]           period_o,
    output logic                       period_valid_o,
    output logic                       period_upd_o,
    output logic                       period_stale_o,
    output logic [(NCH-1)*CNT_W-1:0]   lag_o,
    output logic [NCH-2:0]             lag_upd_o,
    output logic [NCH-2:0]             lag_err_o
);
    localparam int unsigned NSLV = NCH - 1;

    logic [NCH-1:0] fall;
    logic           m_edge;

    for (genvar c = 0; c < NCH; c++) begin : g_edge
        zcap_edge #(.SYNC_STAGES(ZCAP_SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (zcd_i[c]),
            .fall_o (fall[c])
        );
    end

    zcap_master #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (chan_en_i[0]),
        .edge_i   (fall[0]),
        .period_o (period_o),
        .valid_o  (period_valid_o),
        .upd_o    (period_upd_o),
        .stale_o  (period_stale_o)
    );

    assign m_edge = fall[0] & chan_en_i[0];

    for (genvar s = 0; s < NSLV; s++) begin : g_slv
        zcap_slave #(.CNT_W(CNT_W)) u_slave (
            .clk            (clk),
            .rst_n          (rst_n),
            .en_i           (chan_en_i[s+1]),
            .m_edge_i       (m_edge),
            .s_edge_i       (fall[s+1]),
            .period_i       (period_o),
            .period_valid_i (period_valid_o),
            .lag_o          (lag_o[s*CNT_W +: CNT_W]),
            .upd_o          (lag_upd_o[s]),
            .err_o          (lag_err_o[s])
        );
    end

endmodule

// File: tb/test_zcd_capture.sv
`timescale 1ns/1ps
module test_zcd_capture;
    localparam int NCH     = 3;
    localparam int CNT_W   = 8;
    localparam int TIMEOUT = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] zcd = '1;
    logic [NCH-1:0] en = '1;
    logic [CNT_W-1:0] period_o;
    logic period_valid_o, period_upd_o, period_stale_o;
    logic [(NCH-1)*CNT_W-1:0] lag_o;
    logic [NCH-2:0] lag_upd_o, lag_err_o;

    always #2.5 clk = ~clk;

    zcd_capture #(.NCH(NCH), .CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) i_zcd_capture (
        .clk(clk), .rst_n(rst_n), .zcd_i(zcd), .chan_en_i(en),
        .period_o(period_o), .period_valid_o(period_valid_o),
        .period_upd_o(period_upd_o), .period_stale_o(period_stale_o),
        .lag_o(lag_o), .lag_upd_o(lag_upd_o), .lag_err_o(lag_err_o)
    );

    // kind: 0 period capture, 1 lag capture, 2 lag rejection
    typedef struct {
        int    kind;
        int    ch;
        int    val;
        string req;
    } exp_t;
    exp_t q[$];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input int k, input int c, input int v, input string r);
        exp_t e;
        e.kind = k; e.ch = c; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic zfall(input int ch);
        zcd[ch] = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                zcd[ch] = 1'b1;
            end
        join_none
    endtask

    function automatic int lag_at(input int ch);
        return int'(lag_o[(ch-1)*CNT_W +: CNT_W]);
    endfunction

    task automatic pop(input int k, input int c, input int v);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "R8", $sformatf("unexpected event kind %0d ch %0d", k, c), v, -1);
        end else begin
            e = q.pop_front();
            check(e.kind == k && e.ch == c, e.req,
                  $sformatf("event kind/ch (got %0d/%0d want %0d/%0d)", k, c, e.kind, e.ch),
                  k * 10 + c, e.kind * 10 + e.ch);
            if (e.kind == k && k != 2)
                check(e.val == v, e.req, $sformatf("value kind %0d ch %0d", k, c), v, e.val);
        end
    endtask

    // Monitor: pops the scoreboard as results appear (period first, then slaves).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (period_upd_o) pop(0, 0, int'(period_o));
            for (int i = 1; i < NCH; i++) begin
                if (lag_upd_o[i-1]) pop(1, i, lag_at(i));
                if (lag_err_o[i-1]) pop(2, i, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected completion", 200000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(4);
        // Reset state (R3)
        check(period_o == 0 && !period_valid_o && !period_upd_o && !period_stale_o,
              "R3", "reset period outputs", int'(period_o), 0);
        check(lag_o == 0 && lag_upd_o == 0 && lag_err_o == 0, "R3", "reset lag outputs", int'(lag_o), 0);
        rst_n = 1'b1;
        step(5);

        // First master edge: no capture (R3); slave before any period is rejected (R7)
        zfall(0);                 step(10);
        push(2, 1, 0, "R7");      zfall(1); step(30);
        push(0, 0, 40, "R2");     zfall(0); step(15);
        push(1, 2, 15, "R6");     zfall(2); step(10);
        push(1, 1, 25, "R6");     zfall(1); step(5);
        check(period_valid_o && !period_stale_o, "R3", "valid after first capture",
              int'(period_valid_o), 1);
        step(20);
        push(0, 0, 50, "R2");     zfall(0); step(8);
        push(1, 1, 8, "R6");      zfall(1); step(10);
        // Slave edge while armed: ignored (R8)
        zfall(1); step(32);
        check(lag_at(1) == 8, "R8", "lag1 after armed edge", lag_at(1), 8);
        // Master and slave together: lag equal to period is rejected (R7)
        push(0, 0, 50, "R2");     push(2, 2, 0, "R7");
        zfall(0); zfall(2);       step(60);
        push(2, 1, 0, "R7");      zfall(1); step(20);
        push(0, 0, 80, "R2");     zfall(0); step(79);
        push(1, 1, 79, "R7");     zfall(1); step(1);
        push(2, 2, 0, "R7");      zfall(2); step(10);
        check(lag_at(2) == 15, "R7", "lag2 held after rejection", lag_at(2), 15);
        push(0, 0, 90, "R2");     zfall(0); step(20);
        // Master restart of lag count (R8)
        push(0, 0, 20, "R2");     zfall(0); step(5);
        push(1, 1, 5, "R8");      zfall(1); step(15);
        push(0, 0, 20, "R2");     zfall(0); step(300);
        // Saturation (R10)
        push(0, 0, 255, "R10");   zfall(0); step(600);
        // Interval equal to TIMEOUT still captured (R4)
        push(0, 0, 255, "R4");    zfall(0); step(650);
        check(period_stale_o == 1'b1, "R4", "stale after timeout", int'(period_stale_o), 1);
        check(period_o == 255, "R4", "period held while stale", int'(period_o), 255);
        step(50);
        zfall(0); step(6);
        check(period_stale_o == 1'b0, "R4", "stale cleared by edge", int'(period_stale_o), 0);
        step(24);
        push(0, 0, 30, "R2");     zfall(0);
        // Slave 2 disabled (R9)
        en[2] = 1'b0;             step(5);
        zfall(2);                 step(5);
        push(1, 1, 10, "R6");     zfall(1); step(20);
        push(0, 0, 30, "R2");     zfall(0); step(30);
        check(lag_at(2) == 15, "R9", "disabled slave lag unchanged", lag_at(2), 15);
        en[2] = 1'b1;             step(10);
        push(0, 0, 40, "R2");     zfall(0); step(12);
        push(1, 2, 12, "R9");     zfall(2); step(28);
        // Master disabled (R9, R3)
        en[0] = 1'b0;             step(5);
        check(period_valid_o == 1'b0, "R9", "valid cleared on master disable",
              int'(period_valid_o), 0);
        check(period_o == 40, "R5", "period held while disabled", int'(period_o), 40);
        zfall(0); step(20);
        zfall(0); step(10);
        en[0] = 1'b1;             step(5);
        zfall(0);                 step(25);
        push(0, 0, 25, "R3");     zfall(0); step(10);
        check(period_valid_o == 1'b1, "R3", "valid after re-enable capture",
              int'(period_valid_o), 1);
        step(20);
        check(q.size() == 0, "R1", "all expected events produced", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule